// File: doc/BRIEF.md
# Electrically Erasable EPROM Programming Sequencer

This block runs a byte-wide, electrically erasable EPROM through its pins. It erases and blank-checks the device, or it programs it from a byte stream. A host pulses `start` and picks the operation with `op_program`. For a program run, the host then offers address/data beats on a ready/valid stream and marks the final beat with `in_last`. The sequencer drives the chip-select, output-enable and program-strobe lines. It drives the address bus and a tristated data bus. It also drives three digital selects: logic-supply-good, the erase-level or program-level programming supply, and the high-voltage level on the identifier address pin. Every delay is a parameter counted in clock cycles.

An erase run raises the erase supply with the identifier pin at high voltage. It fires one whole-array strobe, then reads every address back in ascending order and expects all ones. A program run handles one byte per accepted beat. It first reads the target byte and rejects a request that would need a 0 turned back into a 1. It then strobes the byte in, reads it back in verify mode and compares. Any failure stops the run at once with no retry. A one-cycle `done` pulse reports the pass flag and the first failing address.

Top module: `eprom_prog_seq`

## Requirements
- R1: While reset is held, and afterwards until `start`: `dev_ce_n`, `dev_oe_n` and `dev_pgm_n` are 1. `dev_dq_oe`, `vcc_good`, every supply select, `done`, `pass` and `in_ready` are 0.
- R2: `vcc_good` is high for at least T_PWR cycles before either supply select rises. At the end of a run it stays high for at least T_PWR cycles after the select has fallen.
- R3: An erase run (`start` with `op_program`=0) strobes `dev_pgm_n` low for exactly T_ERASE cycles, once. During the strobe: `vpp_erase_sel` and `id_hv_sel` are 1, `dev_ce_n` is 0, `dev_oe_n` is 1, the address is all zeros and the bus drives 0xFF. Afterwards every byte holds 0xFF.
- R4: After the erase strobe, every address from 0 to 2^AW-1 is read in ascending order with `dev_ce_n`=0, `dev_oe_n`=0, `dev_pgm_n`=1 and the erase supply on. The first byte that differs from 0xFF ends the run and is reported in `fail_addr`.
- R5: A program run (`start` with `op_program`=1) accepts one beat per byte. For each accepted byte it strobes `dev_pgm_n` low for exactly T_PROG cycles with `vpp_prog_sel`=1, `dev_ce_n`=0, `dev_oe_n`=1, and the beat's address and data on the buses.
- R6: After each strobe the byte is read back with the program supply still on. If it differs from the requested data, the run ends and reports that address.
- R7: Before strobing, the byte is read. If the request has a 1 where the read byte has a 0, the run fails at that address with no strobe and no change to the array.
- R8: Each read is sampled after `dev_oe_n` has been low for T_OE full cycles. Data that appears earlier is not used.
- R9: `dev_dq_oe` and a low `dev_oe_n` never coincide. `dev_dq_oe` is low in the cycle before every falling edge of `dev_oe_n`.
- R10: Each run ends with `done` high for exactly one cycle. `pass` and `fail_addr` are valid then and are held until the next `start`. A program run passes after the beat marked `in_last` verifies.
- R11: `in_ready` is high only while a program run waits for a beat. `in_valid` has no effect at any other time. `start` is ignored while a run is in progress.
- R12: `vpp_erase_sel` and `vpp_prog_sel` are never both high, and `id_hv_sel` is high only with `vpp_erase_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a run |
| op_program | input | 1 | 1 = program from stream, 0 = erase and blank-check |
| in_valid | input | 1 | Stream beat offered |
| in_ready | output | 1 | Stream beat accepted this cycle if valid |
| in_addr | input | AW | Target byte address |
| in_data | input | DW | Byte value to program |
| in_last | input | 1 | Beat is the final one of the run |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Run result, 1 = success |
| fail_addr | output | AW | First failing address (0 on pass) |
| dev_ce_n | output | 1 | Device chip select, active low |
| dev_oe_n | output | 1 | Device output enable, active low |
| dev_pgm_n | output | 1 | Device program/erase strobe, active low |
| dev_addr | output | AW | Device address bus |
| dev_dq_out | output | DW | Data driven toward the device |
| dev_dq_oe | output | 1 | Enable for the data bus drivers |
| dev_dq_in | input | DW | Data read from the device |
| vcc_good | output | 1 | Logic supply asserted |
| vpp_erase_sel | output | 1 | Programming supply at erase level |
| vpp_prog_sel | output | 1 | Programming supply at program level |
| id_hv_sel | output | 1 | High voltage on the identifier address pin |

## Verification
A read's result takes effect at the end of the cycle in which `dev_oe_n` has been low for T_OE cycles. The bench's device model returns the inverted byte until then, so a sample taken one cycle early shows up as a wrong verdict. `done` follows a failing or final read by T_PWR+1 cycles. The bench waits for the pulse and reads `pass` and `fail_addr` at the falling edge in which `done` is high. Pulse lengths, supply lead and lag, and bus turnaround are measured by falling-edge monitors that count cycles from the observed edges. Expected array contents come from a shadow array that applies each accepted request by the program-only-clears rule.

// File: rtl/eprom_seq_pkg.sv
// Shared types for the EPROM programming sequencer.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package eprom_seq_pkg;

    typedef enum logic [4:0] {
        S_IDLE,
        S_PWR_ON,
        S_VPP_ON,
        S_E_SET,
        S_E_PULSE,
        S_E_HOLD,
        S_E_GAP,
        S_E_READ,
        S_P_WAIT,
        S_P_GAP0,
        S_P_PRE,
        S_P_SET,
        S_P_PULSE,
        S_P_HOLD,
        S_P_GAP1,
        S_P_VER,
        S_VPP_OFF,
        S_FIN
    } seq_state_e;

    typedef enum logic [1:0] {
        CHK_BLANK,
        CHK_FIT,
        CHK_EXACT
    } chk_mode_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic pgm_n;
        logic dq_oe;
        logic vcc_good;
        logic vpp_erase;
        logic vpp_prog;
        logic id_hv;
        logic addr_zero;
        logic data_ones;
    } pin_ctl_t;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/seq_timer.sv
// Per-state cycle counter. Restarts at zero whenever the sequencer changes
// state and raises expire in the cycle whose count equals limit-1.
// Assumes: limit >= 1 and fits in TW bits.
module seq_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic [TW-1:0] limit,
    output logic          expire
);
    logic [TW-1:0] cnt;

    // Count cycles spent in the current state, holding once expired.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (!expire) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expire = (cnt == limit - 1'b1);
endmodule

// File: rtl/verify_check.sv
// Combinational judgement of a byte read from the device.
// BLANK: all ones. FIT: request clears only bits (no 0->1 needed).
// EXACT: read equals request.
// Assumes: caller samples ok only at the valid read point.
module verify_check
    import eprom_seq_pkg::*;
#(
    parameter int DW = 8
) (
    input  chk_mode_e     mode,
    input  logic [DW-1:0] rd,
    input  logic [DW-1:0] want,
    output logic          ok
);
    // Select the comparison rule for the current read.
    always_comb begin
        case (mode)
            CHK_BLANK: ok = &rd;
            CHK_FIT:   ok = ((want & ~rd) == '0);
            default:   ok = (rd == want);
        endcase
    end
endmodule

// File: rtl/pin_drive.sv
// Decodes the sequencer state into device pin levels and supply selects.
// Assumes: state is a registered value so outputs change only after edges.
module pin_drive
    import eprom_seq_pkg::*;
(
    input  seq_state_e state,
    input  logic       op_erase,
    output pin_ctl_t   pins
);
    // Map each state to its pin pattern; default is fully idle.
    always_comb begin
        pins           = '0;
        pins.ce_n      = 1'b1;
        pins.oe_n      = 1'b1;
        pins.pgm_n     = 1'b1;
        case (state)
            S_PWR_ON, S_VPP_OFF: begin
                pins.vcc_good = 1'b1;
            end
            S_VPP_ON: begin
                pins.vcc_good  = 1'b1;
                pins.vpp_erase = op_erase;
                pins.vpp_prog  = !op_erase;
            end
            S_E_SET, S_E_PULSE, S_E_HOLD: begin
                pins.vcc_good  = 1'b1;
                pins.vpp_erase = 1'b1;
                pins.id_hv     = 1'b1;
                pins.ce_n      = 1'b0;
                pins.dq_oe     = 1'b1;
                pins.addr_zero = 1'b1;
                pins.data_ones = 1'b1;
                pins.pgm_n     = (state != S_E_PULSE);
            end
            S_E_GAP, S_E_READ: begin
                pins.vcc_good  = 1'b1;
                pins.vpp_erase = 1'b1;
                pins.ce_n      = 1'b0;
                pins.oe_n      = (state != S_E_READ);
            end
            S_P_WAIT, S_P_GAP0, S_P_GAP1, S_P_PRE, S_P_VER: begin
                pins.vcc_good = 1'b1;
                pins.vpp_prog = 1'b1;
                pins.ce_n     = 1'b0;
                pins.oe_n     = !(state == S_P_PRE || state == S_P_VER);
            end
            S_P_SET, S_P_PULSE, S_P_HOLD: begin
                pins.vcc_good = 1'b1;
                pins.vpp_prog = 1'b1;
                pins.ce_n     = 1'b0;
                pins.dq_oe    = 1'b1;
                pins.pgm_n    = (state != S_P_PULSE);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/eprom_prog_seq.sv
// Top of the EPROM programming sequencer. Runs either a whole-array erase
// with ascending blank check, or a per-byte program flow (fit check, strobe,
// verify) fed by a ready/valid stream. Stops on the first failure.
// Assumes: the external supply switches follow the select outputs within the
// T_PWR margin; all delays are counted in clk cycles.
module eprom_prog_seq
    import eprom_seq_pkg::*;
#(
    parameter int AW      = 10,
    parameter int DW      = 8,
    parameter int T_PWR   = 4,
    parameter int T_SETUP = 3,
    parameter int T_HOLD  = 2,
    parameter int T_ERASE = 50,
    parameter int T_PROG  = 10,
    parameter int T_OE    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          op_program,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_data,
    input  logic          in_last,
    output logic          done,
    output logic          pass,
    output logic [AW-1:0] fail_addr,
    output logic          dev_ce_n,
    output logic          dev_oe_n,
    output logic          dev_pgm_n,
    output logic [AW-1:0] dev_addr,
    output logic [DW-1:0] dev_dq_out,
    output logic          dev_dq_oe,
    input  logic [DW-1:0] dev_dq_in,
    output logic          vcc_good,
    output logic          vpp_erase_sel,
    output logic          vpp_prog_sel,
    output logic          id_hv_sel
);
    localparam int T_MAX = max_int(max_int(max_int(T_ERASE, T_PROG), max_int(T_PWR, T_SETUP)),
                                   max_int(T_HOLD, T_OE + 1));
    localparam int TW    = $clog2(T_MAX + 1) + 1;

    seq_state_e    state, state_nx;
    logic          op_erase;
    logic [AW-1:0] cur_addr;
    logic [DW-1:0] want;
    logic          last_q;
    logic          pass_q;
    logic [AW-1:0] fail_q;
    logic [TW-1:0] lim;
    logic          expire;
    logic          rd_ok;
    logic          is_read;
    logic          addr_max;
    chk_mode_e     mode;
    pin_ctl_t      pins;

    // Cycle budget of the current state.
    always_comb begin
        case (state)
            S_PWR_ON, S_VPP_ON, S_VPP_OFF: lim = TW'(T_PWR);
            S_E_SET, S_P_SET:              lim = TW'(T_SETUP);
            S_E_PULSE:                     lim = TW'(T_ERASE);
            S_P_PULSE:                     lim = TW'(T_PROG);
            S_E_HOLD, S_P_HOLD:            lim = TW'(T_HOLD);
            S_E_READ, S_P_PRE, S_P_VER:    lim = TW'(T_OE + 1);
            default:                       lim = TW'(1);
        endcase
    end

    seq_timer #(.TW(TW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (state_nx != state),
        .limit  (lim),
        .expire (expire)
    );

    // Pick the comparison rule from the read phase.
    always_comb begin
        case (state)
            S_E_READ: mode = CHK_BLANK;
            S_P_PRE:  mode = CHK_FIT;
            default:  mode = CHK_EXACT;
        endcase
    end

    verify_check #(.DW(DW)) u_check (
        .mode (mode),
        .rd   (dev_dq_in),
        .want (want),
        .ok   (rd_ok)
    );

    pin_drive u_pins (
        .state    (state),
        .op_erase (op_erase),
        .pins     (pins)
    );

    assign is_read  = (state == S_E_READ) || (state == S_P_PRE) || (state == S_P_VER);
    assign addr_max = &cur_addr;

    // Next-state sequencing of the erase and program flows.
    always_comb begin
        state_nx = state;
        case (state)
            S_IDLE:    if (start)  state_nx = S_PWR_ON;
            S_PWR_ON:  if (expire) state_nx = S_VPP_ON;
            S_VPP_ON:  if (expire) state_nx = op_erase ? S_E_SET : S_P_WAIT;
            S_E_SET:   if (expire) state_nx = S_E_PULSE;
            S_E_PULSE: if (expire) state_nx = S_E_HOLD;
            S_E_HOLD:  if (expire) state_nx = S_E_GAP;
            S_E_GAP:   if (expire) state_nx = S_E_READ;
            S_E_READ:  if (expire) state_nx = (!rd_ok || addr_max) ? S_VPP_OFF : S_E_GAP;
            S_P_WAIT:  if (in_valid) state_nx = S_P_GAP0;
            S_P_GAP0:  if (expire) state_nx = S_P_PRE;
            S_P_PRE:   if (expire) state_nx = rd_ok ? S_P_SET : S_VPP_OFF;
            S_P_SET:   if (expire) state_nx = S_P_PULSE;
            S_P_PULSE: if (expire) state_nx = S_P_HOLD;
            S_P_HOLD:  if (expire) state_nx = S_P_GAP1;
            S_P_GAP1:  if (expire) state_nx = S_P_VER;
            S_P_VER:   if (expire) state_nx = (!rd_ok || last_q) ? S_VPP_OFF : S_P_WAIT;
            S_VPP_OFF: if (expire) state_nx = S_FIN;
            S_FIN:     if (expire) state_nx = S_IDLE;
            default:   state_nx = S_IDLE;
        endcase
    end

    // State, run context, beat capture and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            op_erase <= 1'b0;
            cur_addr <= '0;
            want     <= '0;
            last_q   <= 1'b0;
            pass_q   <= 1'b0;
            fail_q   <= '0;
        end else begin
            state <= state_nx;
            if (state == S_IDLE && start) begin
                op_erase <= !op_program;
                cur_addr <= '0;
                pass_q   <= 1'b1;
                fail_q   <= '0;
            end
            if (state == S_P_WAIT && in_valid) begin
                cur_addr <= in_addr;
                want     <= in_data;
                last_q   <= in_last;
            end
            if (is_read && expire && !rd_ok) begin
                pass_q <= 1'b0;
                fail_q <= cur_addr;
            end
            if (state == S_E_READ && expire && rd_ok && !addr_max) begin
                cur_addr <= cur_addr + 1'b1;
            end
        end
    end

    assign in_ready      = (state == S_P_WAIT);
    assign done          = (state == S_FIN);
    assign pass          = pass_q;
    assign fail_addr     = fail_q;
    assign dev_ce_n      = pins.ce_n;
    assign dev_oe_n      = pins.oe_n;
    assign dev_pgm_n     = pins.pgm_n;
    assign dev_dq_oe     = pins.dq_oe;
    assign dev_addr      = pins.addr_zero ? '0 : cur_addr;
    assign dev_dq_out    = pins.data_ones ? '1 : want;
    assign vcc_good      = pins.vcc_good;
    assign vpp_erase_sel = pins.vpp_erase;
    assign vpp_prog_sel  = pins.vpp_prog;
    assign id_hv_sel     = pins.id_hv;
endmodule

// File: rtl/eprom_prog_seq_chk.sv
// Protocol checker for the sequencer's device-side and host-side pins.
// Assumes: attached to every instance of eprom_prog_seq through bind.
module eprom_prog_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic done,
    input logic in_ready,
    input logic dev_ce_n,
    input logic dev_oe_n,
    input logic dev_pgm_n,
    input logic dev_dq_oe,
    input logic vcc_good,
    input logic vpp_erase_sel,
    input logic vpp_prog_sel,
    input logic id_hv_sel
);
    logic vpp_any;
    assign vpp_any = vpp_erase_sel || vpp_prog_sel;

    // R12
    sel_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(vpp_erase_sel && vpp_prog_sel));

    // R12
    hv_needs_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        id_hv_sel |-> vpp_erase_sel);

    // R2
    vpp_after_vcc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vpp_any) |-> $past(vcc_good));

    // R2
    vcc_after_vpp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vcc_good) |-> (!vpp_any && $past(!vpp_any)));

    // R9
    bus_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dev_dq_oe && !dev_oe_n));

    // R9
    oe_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dev_oe_n) |-> $past(!dev_dq_oe));

    // R3
    hv_pin_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        id_hv_sel |-> (!dev_ce_n && dev_oe_n));

    // R5
    strobe_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_pgm_n |-> (!dev_ce_n && dev_oe_n && dev_dq_oe && vpp_any));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    ready_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (vpp_prog_sel && !dev_ce_n));
endmodule

bind eprom_prog_seq eprom_prog_seq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .done          (done),
    .in_ready      (in_ready),
    .dev_ce_n      (dev_ce_n),
    .dev_oe_n      (dev_oe_n),
    .dev_pgm_n     (dev_pgm_n),
    .dev_dq_oe     (dev_dq_oe),
    .vcc_good      (vcc_good),
    .vpp_erase_sel (vpp_erase_sel),
    .vpp_prog_sel  (vpp_prog_sel),
    .id_hv_sel     (id_hv_sel)
);

// File: tb/eprom_prog_seq_test.sv
// Bench for eprom_prog_seq: behavioural device model, pin monitors,
// directed corner cases and seeded random program streams.
module eprom_prog_seq_test;
    localparam int AW = 10, DW = 8;
    localparam int T_PWR = 4, T_SETUP = 3, T_HOLD = 2, T_ERASE = 50, T_PROG = 10, T_OE = 3;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, op_program = 1'b0;
    logic in_valid = 1'b0, in_last = 1'b0;
    logic [AW-1:0] in_addr = '0;
    logic [DW-1:0] in_data = '0;
    logic in_ready, done, pass;
    logic [AW-1:0] fail_addr, dev_addr;
    logic dev_ce_n, dev_oe_n, dev_pgm_n, dev_dq_oe;
    logic [DW-1:0] dev_dq_out, dev_dq_in;
    logic vcc_good, vpp_erase_sel, vpp_prog_sel, id_hv_sel;

    always #5 clk = ~clk;

    eprom_prog_seq #(.AW(AW), .DW(DW), .T_PWR(T_PWR), .T_SETUP(T_SETUP), .T_HOLD(T_HOLD),
                     .T_ERASE(T_ERASE), .T_PROG(T_PROG), .T_OE(T_OE)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_program(op_program),
        .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr), .in_data(in_data),
        .in_last(in_last), .done(done), .pass(pass), .fail_addr(fail_addr),
        .dev_ce_n(dev_ce_n), .dev_oe_n(dev_oe_n), .dev_pgm_n(dev_pgm_n),
        .dev_addr(dev_addr), .dev_dq_out(dev_dq_out), .dev_dq_oe(dev_dq_oe),
        .dev_dq_in(dev_dq_in), .vcc_good(vcc_good), .vpp_erase_sel(vpp_erase_sel),
        .vpp_prog_sel(vpp_prog_sel), .id_hv_sel(id_hv_sel));

    // ---------------- device model ----------------
    logic [DW-1:0] mem [DEPTH];
    int oe_cnt = 0;
    int stuck_e = -1;
    int weak_p = -1;

    always @(posedge clk) begin
        oe_cnt <= dev_oe_n ? 0 : oe_cnt + 1;
        if (!dev_pgm_n && !dev_ce_n && dev_oe_n) begin
            if (vpp_erase_sel && id_hv_sel) begin
                for (int i = 0; i < DEPTH; i++) mem[i] <= (i == stuck_e) ? 8'hEF : 8'hFF;
            end else if (vpp_prog_sel) begin
                mem[dev_addr] <= mem[dev_addr] &
                                 (dev_dq_out | ((int'(dev_addr) == weak_p) ? 8'h01 : 8'h00));
            end
        end
    end

    // Data becomes valid only after T_OE cycles of output enable; before that it is inverted.
    assign dev_dq_in = (!dev_ce_n && !dev_oe_n && !dev_dq_oe) ?
                       ((oe_cnt >= T_OE) ? mem[dev_addr] : ~mem[dev_addr]) : 8'h00;

    // ---------------- monitors ----------------
    int total = 0, fails = 0;
    int done_cnt = 0, done_wide = 0, pulses = 0, lo_len = 0, last_len = 0;
    int quiet = 0, min_lead = 1000, min_lag = 1000;
    int contention = 0, both_sel = 0, ready_bad = 0, erase_pin_bad = 0;
    logic done_q = 1'b0, pgm_q = 1'b1, vpp_q = 1'b0, vcc_q = 1'b0, in_erase_op = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (done) done_cnt++;
            if (done && done_q) done_wide++;
            if (pgm_q && !dev_pgm_n) pulses++;
            if (!dev_pgm_n) lo_len++;
            if (!pgm_q && dev_pgm_n) begin last_len = lo_len; lo_len = 0; end
            if ((vpp_erase_sel || vpp_prog_sel) && !vpp_q && quiet < min_lead) min_lead = quiet;
            if (vcc_q && !vcc_good && quiet < min_lag) min_lag = quiet;
            quiet = (vcc_good && !(vpp_erase_sel || vpp_prog_sel)) ? quiet + 1 : 0;
            if (dev_dq_oe && !dev_oe_n) contention++;
            if (vpp_erase_sel && vpp_prog_sel) both_sel++;
            if (in_ready && in_erase_op) ready_bad++;
            if (!dev_pgm_n && vpp_erase_sel &&
                !(dev_addr == 0 && dev_dq_out == 8'hFF && id_hv_sel && !dev_ce_n &&
                  dev_oe_n && dev_dq_oe)) erase_pin_bad++;
        end
        done_q = done;
        pgm_q  = dev_pgm_n;
        vpp_q  = vpp_erase_sel || vpp_prog_sel;
        vcc_q  = vcc_good;
    end

    // ---------------- helpers ----------------
    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_done(input int d0);
        int n = 0;
        while (done_cnt == d0 && n < 40000) begin @(negedge clk); n++; end
        if (done_cnt == d0) begin
            total++; fails++;
            $display("FAIL R10: no done pulse, actual %0d expected %0d", done_cnt, d0 + 1);
        end
    endtask

    task automatic start_op(input logic prog);
        @(negedge clk);
        op_program = prog;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic do_erase();
        int d0 = done_cnt;
        in_erase_op = 1'b1;
        start_op(1'b0);
        wait_done(d0);
        in_erase_op = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    logic [AW-1:0] s_addr [32];
    logic [DW-1:0] s_data [32];
    int s_n = 0;
    logic [DW-1:0] exp_mem [DEPTH];

    task automatic do_program();
        int d0 = done_cnt;
        start_op(1'b1);
        for (int i = 0; i < s_n; i++) begin
            in_valid = 1'b1;
            in_addr  = s_addr[i];
            in_data  = s_data[i];
            in_last  = (i == s_n - 1);
            while (!in_ready && done_cnt == d0) @(negedge clk);
            if (done_cnt != d0) break;
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        wait_done(d0);
        repeat (2) @(negedge clk);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        int p0, d0, bad, ok_ready;
        logic exp_pass;
        logic [AW-1:0] exp_addr;
        void'($urandom(32'd4711));
        for (int i = 0; i < DEPTH; i++) mem[i] <= DW'($urandom);

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 reset pins", {dev_ce_n, dev_oe_n, dev_pgm_n, dev_dq_oe, vcc_good,
                                vpp_erase_sel, vpp_prog_sel, id_hv_sel, done, pass, in_ready},
              11'b111_00000000);
        rst_n = 1'b1;

        // R11: stream ignored while idle
        ok_ready = 1;
        in_valid = 1'b1;
        repeat (5) begin @(negedge clk); if (in_ready) ok_ready = 0; end
        in_valid = 1'b0;
        check("R11 idle in_ready", ok_ready, 1);
        check("R1 idle after reset", {vcc_good, dev_ce_n}, 2'b01);

        // R3/R4/R8/R11: erase with stream offered and a second start mid-run
        p0 = pulses; d0 = done_cnt;
        in_valid = 1'b1;
        in_erase_op = 1'b1;
        start_op(1'b0);
        repeat (30) @(negedge clk);
        start = 1'b1; @(negedge clk); start = 1'b0;
        wait_done(d0);
        in_erase_op = 1'b0;
        in_valid = 1'b0;
        check("R4 R8 erase pass", pass, 1);
        check("R10 erase fail_addr on pass", fail_addr, 0);
        repeat (40) @(negedge clk);
        check("R11 start ignored while busy", done_cnt, d0 + 1);
        check("R3 single erase strobe", pulses - p0, 1);
        check("R3 erase strobe length", last_len, T_ERASE);
        bad = 0;
        for (int i = 0; i < DEPTH; i++) if (mem[i] !== 8'hFF) bad++;
        check("R3 array blank", bad, 0);

        // R4: stuck byte found, first failing address reported
        stuck_e = 677;
        do_erase();
        check("R4 stuck erase pass", pass, 0);
        check("R4 stuck erase addr", fail_addr, 677);
        stuck_e = -1;
        do_erase();
        check("R4 clean erase pass", pass, 1);

        // R5/R6/R10: directed program incl. first and last address
        p0 = pulses;
        s_addr[0] = 0;    s_data[0] = 8'hA5;
        s_addr[1] = 1023; s_data[1] = 8'h3C;
        s_addr[2] = 512;  s_data[2] = 8'h00;
        s_n = 3;
        do_program();
        check("R10 R8 program pass", pass, 1);
        check("R5 strobes per byte", pulses - p0, 3);
        check("R5 program strobe length", last_len, T_PROG);
        check("R6 contents", {mem[0], mem[1023], mem[512]}, 24'hA53C00);

        // R7: request needs 0->1, no strobe
        p0 = pulses;
        s_addr[0] = 0; s_data[0] = 8'hA7; s_n = 1;
        do_program();
        check("R7 fit fail pass", pass, 0);
        check("R7 fit fail addr", fail_addr, 0);
        check("R7 no strobe", pulses - p0, 0);
        check("R7 byte untouched", mem[0], 8'hA5);

        // R6: weak cell fails verify
        do_erase();
        weak_p = 16;
        p0 = pulses;
        s_addr[0] = 5; s_data[0] = 8'h12;
        s_addr[1] = 16; s_data[1] = 8'h40;
        s_n = 2;
        do_program();
        check("R6 verify fail pass", pass, 0);
        check("R6 verify fail addr", fail_addr, 16);
        check("R6 strobes before fail", pulses - p0, 2);
        check("R6 earlier byte kept", mem[5], 8'h12);
        weak_p = -1;

        // R5/R6/R7: seeded random streams over a small window with repeats
        do_erase();
        for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'hFF;
        for (int r = 0; r < 8; r++) begin
            s_n = 6 + int'($urandom % 10);
            exp_pass = 1'b1;
            exp_addr = '0;
            for (int i = 0; i < s_n; i++) begin
                s_addr[i] = AW'($urandom % 32);
                s_data[i] = DW'($urandom);
                if ($urandom % 4 != 0) s_data[i] = s_data[i] & exp_mem[s_addr[i]];
                if (exp_pass) begin
                    if ((s_data[i] & ~exp_mem[s_addr[i]]) != 0) begin
                        exp_pass = 1'b0;
                        exp_addr = s_addr[i];
                    end else begin
                        exp_mem[s_addr[i]] = exp_mem[s_addr[i]] & s_data[i];
                    end
                end
            end
            do_program();
            check("R7 random pass flag", pass, exp_pass);
            check("R7 random fail addr", fail_addr, exp_addr);
            bad = 0;
            for (int a = 0; a < 32; a++) if (mem[a] !== exp_mem[a]) bad++;
            check("R6 random contents", bad, 0);
        end

        // Pin-level monitors
        check("R2 supply lead", min_lead >= T_PWR, 1);
        check("R2 supply lag", min_lag >= T_PWR, 1);
        check("R3 erase strobe pins", erase_pin_bad, 0);
        check("R9 bus contention", contention, 0);
        check("R10 done width", done_wide, 0);
        check("R11 ready outside program", ready_bad, 0);
        check("R12 exclusive selects", both_sel, 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule